// File: doc/BRIEF.md
# Watchdog and Interval Timer with Write-Once Mode Control

This block watches for a stalled program. It divides the system clock by a selectable power of two and counts the divided ticks in a small counter. When that counter wraps, the block takes one of three actions. It can raise a maskable interrupt, which makes it a plain interval timer. It can raise a non-maskable interrupt. Or it can request a system reset. Software selects the action, and starts counting, through one 8-bit mode register.

Software keeps the block quiet by writing a 1 to the run bit often enough. Each such write clears the counter and starts a new full period. The run bit and both action bits are write-once-to-one: after software sets one of them, only a hardware reset clears it. This stops runaway code from turning the watchdog off.

The divider runs freely and a restart does not clear it. So the first period after a service can end up to one divided tick early. An interrupt-pending flag is set on every wrap and stays set until software pulses a clear strobe. If software moves the block into a non-maskable mode while that flag is pending, a non-maskable interrupt is raised at once.

Top module: `wdog_timer`

## Requirements
- R1: After hardware reset the mode register reads 0x00, the pending flag is 0 and all three event outputs are low.
- R2: The mode register holds the run bit at bit 7, action bit A at bit 4 and action bit B at bit 3. Bits 6, 5, 2, 1 and 0 always read 0, so writing 0xFF reads back 0x98.
- R3: With A = 0, each counter wrap gives one maskable interrupt pulse, and B has no effect on this.
- R4: With A = 1 and B = 0, each counter wrap gives one non-maskable interrupt pulse.
- R5: With A = 1 and B = 1, each counter wrap gives one reset-request pulse.
- R6: Once A or B is 1, a register write cannot clear it. Only hardware reset clears it.
- R7: While the run bit is 0 the counter does not advance and no wrap event happens. Once the run bit is 1, a register write cannot clear it.
- R8: Each write with bit 7 = 1 clears the counter. The first event after such a write comes between (N-1)·P+1 and N·P clock cycles after the write edge, where N = 2^CNT_W and P is the selected division. Servicing more often than that prevents every event.
- R9: The interval-select input chooses P = 2^(PRE_BASE + PRE_STEP·sel). In steady running, consecutive events are exactly N·P cycles apart.
- R10: Every counter wrap sets the pending flag. A one-cycle pulse on the clear strobe clears it, and a wrap in the same cycle wins over the clear.
- R11: A write that takes A from 0 to 1 while the pending flag is 1 gives a non-maskable interrupt pulse in the cycle right after the write edge, whatever value B has. The same write with the flag at 0, or with A already 1, gives no such pulse.
- R12: Each event output is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| reg_wr | input | 1 | Write strobe for the mode register |
| reg_wdata | input | 8 | Write data for the mode register |
| reg_rdata | output | 8 | Current contents of the mode register |
| isel | input | SEL_W | Divider select, chooses the interval |
| flag_clr | input | 1 | Clears the interrupt-pending flag |
| irq_flag | output | 1 | Interrupt-pending flag |
| mirq_pulse | output | 1 | Maskable interrupt request pulse |
| nmi_pulse | output | 1 | Non-maskable interrupt request pulse |
| rst_req_pulse | output | 1 | System reset request pulse |

## Verification
The bench runs every interval select in each of the four action encodings. For each one it measures both the first event after a restart and the steady spacing between events. A design that cleared the divider on restart, or that counted one tick too many or too few, would break the exact spacing or the bounds after restart. The bench also writes zeros after ones to check the write-once bits, and services the block faster than one period to confirm that nothing fires. A design that let software clear those bits, or that did not reset the counter on a service write, would be caught here. The early non-maskable interrupt is tested with the flag set and with the flag clear, and also with A already at 1. A design that checked the written level of A rather than its 0-to-1 change, or that ignored the pending flag, would fire at the wrong time.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

    localparam int RUN_POS = 7;
    localparam int ACTA_POS = 4;
    localparam int ACTB_POS = 3;

    typedef struct packed {
        logic run;
        logic act_a;
        logic act_b;
    } mode_t;

    typedef enum logic [1:0] {
        ACT_MIRQ  = 2'd0,
        ACT_NMI   = 2'd1,
        ACT_RESET = 2'd2
    } wrap_act_e;

    function automatic wrap_act_e decode_act(mode_t m);
        if (!m.act_a)      return ACT_MIRQ;
        else if (!m.act_b) return ACT_NMI;
        else               return ACT_RESET;
    endfunction

    function automatic logic [7:0] pack_mode(mode_t m);
        logic [7:0] r;
        r = 8'h00;
        r[RUN_POS]  = m.run;
        r[ACTA_POS] = m.act_a;
        r[ACTB_POS] = m.act_b;
        return r;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
`timescale 1ns/1ps
module wdog_prescaler #(
    parameter int BASE  = 9,
    parameter int STEP  = 2,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] isel,
    output logic             tick
);
    localparam int NSEL = 1 << SEL_W;
    localparam int PW   = BASE + STEP * (NSEL - 1);

    logic [PW-1:0]   pre_q;
    logic [NSEL-1:0] tap_hit;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_tap
            localparam int L = BASE + STEP * g;
            assign tap_hit[g] = &pre_q[L-1:0];
        end
    endgenerate

    assign tick = tap_hit[isel];
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic restart,
    output logic wrap
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap = run && tick && (&cnt_q) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart)    cnt_q <= '0;
        else if (run && tick)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdog_modereg.sv
`timescale 1ns/1ps
module wdog_modereg
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [7:0]  wdata,
    output mode_t       mode,
    output logic        restart,
    output logic        a_rise,
    output logic [7:0]  rdata
);
    mode_t mode_q;
    logic  unused_wbits;

    assign unused_wbits = ^{wdata[6:5], wdata[2:0]};
    assign restart = wr && wdata[RUN_POS];
    assign a_rise  = wr && wdata[ACTA_POS] && !mode_q.act_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr) begin
            mode_q.run   <= mode_q.run   | wdata[RUN_POS];
            mode_q.act_a <= mode_q.act_a | wdata[ACTA_POS];
            mode_q.act_b <= mode_q.act_b | wdata[ACTB_POS];
        end
    end

    assign mode  = mode_q;
    assign rdata = pack_mode(mode_q);
endmodule

// File: rtl/wdog_events.sv
`timescale 1ns/1ps
module wdog_events
    import wdog_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wrap,
    input  mode_t mode,
    input  logic  a_rise,
    input  logic  flag_clr,
    output logic  flag,
    output logic  mirq,
    output logic  nmi,
    output logic  rreq
);
    wrap_act_e act;
    logic      flag_q;

    assign act = decode_act(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            mirq   <= 1'b0;
            nmi    <= 1'b0;
            rreq   <= 1'b0;
        end else begin
            mirq <= wrap && (act == ACT_MIRQ);
            nmi  <= (wrap && (act == ACT_NMI)) || (a_rise && flag_q);
            rreq <= wrap && (act == ACT_RESET);
            if (wrap)          flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int PRE_BASE = 9,
    parameter int PRE_STEP = 2,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [SEL_W-1:0] isel,
    input  logic             flag_clr,
    output logic             irq_flag,
    output logic             mirq_pulse,
    output logic             nmi_pulse,
    output logic             rst_req_pulse
);
    mode_t mode;
    logic  restart, a_rise, tick, wrap;

    wdog_modereg u_reg (
        .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
        .mode(mode), .restart(restart), .a_rise(a_rise), .rdata(reg_rdata)
    );

    wdog_prescaler #(.BASE(PRE_BASE), .STEP(PRE_STEP), .SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst(rst), .isel(isel), .tick(tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(mode.run), .tick(tick),
        .restart(restart), .wrap(wrap)
    );

    wdog_events u_evt (
        .clk(clk), .rst(rst), .wrap(wrap), .mode(mode), .a_rise(a_rise),
        .flag_clr(flag_clr), .flag(irq_flag), .mirq(mirq_pulse),
        .nmi(nmi_pulse), .rreq(rst_req_pulse)
    );
endmodule

// File: rtl/wdog_chk.sv
`timescale 1ns/1ps
module wdog_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] reg_rdata,
    input logic       irq_flag,
    input logic       mirq_pulse,
    input logic       nmi_pulse,
    input logic       rst_req_pulse
);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[6:5] == 2'b00) && (reg_rdata[2:0] == 3'b000));

    // R6
    acta_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(reg_rdata[4]) |-> reg_rdata[4]);

    // R6
    actb_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(reg_rdata[3]) |-> reg_rdata[3]);

    // R7
    run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(reg_rdata[7]) |-> reg_rdata[7]);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_rdata[7]) |-> !mirq_pulse && !rst_req_pulse);

    // R3
    mirq_mode_chk: assert property (@(posedge clk) disable iff (rst)
        mirq_pulse |-> !$past(reg_rdata[4]));

    // R5
    rreq_mode_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_pulse |-> ($past(reg_rdata[4]) && $past(reg_rdata[3])));

    // R10
    flag_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (mirq_pulse || rst_req_pulse) |-> irq_flag);

    // R12
    mirq_single_chk: assert property (@(posedge clk) disable iff (rst)
        mirq_pulse |=> !mirq_pulse);

    // R12
    rreq_single_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_pulse |=> !rst_req_pulse);
endmodule

bind wdog_timer wdog_chk chk_i (
    .clk(clk), .rst(rst), .reg_rdata(reg_rdata), .irq_flag(irq_flag),
    .mirq_pulse(mirq_pulse), .nmi_pulse(nmi_pulse), .rst_req_pulse(rst_req_pulse)
);

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;
    localparam int CNT_W = 4, PBASE = 2, PSTEP = 1, SEL_W = 2;
    localparam int N = 1 << CNT_W;

    logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, flag_clr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [SEL_W-1:0] isel = '0;
    logic irq_flag, mirq_pulse, nmi_pulse, rst_req_pulse;

    int cyc = 0, total = 0, bad = 0;
    int ev_n = 0, n_m = 0, n_n = 0, n_r = 0, dbl = 0, wr_edge = 0;
    int ev_t[8];
    logic prev_any = 1'b0, any_ev;

    always #4 clk = ~clk;

    wdog_timer #(.CNT_W(CNT_W), .PRE_BASE(PBASE), .PRE_STEP(PSTEP), .SEL_W(SEL_W)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .isel(isel), .flag_clr(flag_clr),
        .irq_flag(irq_flag), .mirq_pulse(mirq_pulse), .nmi_pulse(nmi_pulse),
        .rst_req_pulse(rst_req_pulse)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #2;
        if (!rst) begin
            any_ev = mirq_pulse | nmi_pulse | rst_req_pulse;
            if (any_ev) begin
                if (ev_n < 8) ev_t[ev_n] = cyc;
                ev_n++;
                if (prev_any) dbl++;
            end
            prev_any = any_ev;
            n_m += int'(mirq_pulse);
            n_n += int'(nmi_pulse);
            n_r += int'(rst_req_pulse);
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(string tag, int act, int lo, int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic do_reset(int s);
        rst = 1'b1;
        isel = s[SEL_W-1:0];
        repeat (3) @(posedge clk);
        #1;
        ev_n = 0; n_m = 0; n_n = 0; n_r = 0; prev_any = 1'b0;
        rst = 1'b0;
    endtask

    task automatic wr_reg(logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        wr_edge = cyc;
    endtask

    task automatic clr_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(posedge clk);
        #1;
        flag_clr = 1'b0;
    endtask

    task automatic wait_ev(int n, int limit);
        int k = 0;
        while (ev_n < n && k < limit) begin
            @(negedge clk);
            k++;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        total++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(0);
        @(negedge clk);
        chk("R1 rdata", int'(reg_rdata), 0);
        chk("R1 flag", int'(irq_flag), 0);
        chk("R1 outs", int'({mirq_pulse, nmi_pulse, rst_req_pulse}), 0);

        // R7: not running means no count
        repeat (600) @(negedge clk);
        chk("R7 idle events", ev_n, 0);
        chk("R7 idle flag", int'(irq_flag), 0);

        // R2, R6: layout and stickiness
        wr_reg(8'hFF);
        @(negedge clk);
        chk("R2 readback", int'(reg_rdata), 'h98);
        wr_reg(8'h00);
        @(negedge clk);
        chk("R6 sticky", int'(reg_rdata), 'h98);

        // R3, R4, R5, R8, R9: sweep over action encodings and interval selects
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                int p, mb, em, en, er;
                p = 1 << (PBASE + PSTEP * s);
                mb = (m == 0) ? 'h00 : (m == 1) ? 'h08 : (m == 2) ? 'h10 : 'h18;
                em = (m < 2) ? 2 : 0;
                en = (m == 2) ? 2 : 0;
                er = (m == 3) ? 2 : 0;
                do_reset(s);
                repeat (s + 3) @(negedge clk);
                wr_reg(8'h80 | mb[7:0]);
                wait_ev(2, 3 * N * p);
                chk("R9 event count", ev_n, 2);
                chk_rng("R8 first after restart", ev_t[0] - wr_edge, (N - 1) * p + 1, N * p);
                chk("R9 steady spacing", ev_t[1] - ev_t[0], N * p);
                chk("R3 mirq count", n_m, em);
                chk("R4 nmi count", n_n, en);
                chk("R5 rreq count", n_r, er);
                chk("R10 flag set", int'(irq_flag), 1);
            end
        end

        // R7: a zero write does not stop counting
        do_reset(0);
        wr_reg(8'h80);
        wr_reg(8'h00);
        @(negedge clk);
        chk("R7 run stays", int'(reg_rdata[7]), 1);
        wait_ev(1, 4 * N * 4);
        chk("R7 still counts", n_m, 1);

        // R8: frequent service prevents events
        do_reset(0);
        wr_reg(8'h80);
        for (int i = 0; i < 10; i++) begin
            repeat (40) @(negedge clk);
            wr_reg(8'h80);
        end
        chk("R8 serviced quiet", ev_n, 0);
        wait_ev(1, 4 * N * 4);
        chk_rng("R8 unserviced", ev_t[0] - wr_edge, (N - 1) * 4 + 1, N * 4);

        // R10: clear strobe
        chk("R10 flag before clear", int'(irq_flag), 1);
        clr_flag();
        @(negedge clk);
        chk("R10 flag cleared", int'(irq_flag), 0);

        // R11: A rises while flag pending, B = 1
        do_reset(0);
        wr_reg(8'h80);
        wait_ev(1, 4 * N * 4);
        wr_reg(8'h18);
        @(negedge clk);
        chk("R11 early nmi", n_n, 1);
        chk("R11 nmi timing", ev_t[1] - wr_edge, 0);
        chk("R11 no rreq", n_r, 0);
        wait_ev(3, 4 * N * 4);
        chk("R5 after switch", n_r, 1);

        // R11: A rises with flag clear
        do_reset(0);
        wr_reg(8'h90);
        repeat (3) @(negedge clk);
        chk("R11 no nmi flag clear", n_n, 0);

        // R11: A already 1 with flag pending
        wait_ev(1, 4 * N * 4);
        wr_reg(8'h10);
        repeat (3) @(negedge clk);
        chk("R11 no nmi A already set", n_n, 1);

        // R12: single-cycle pulses throughout
        chk("R12 back-to-back pulses", dbl, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule